// File: doc/BRIEF.md
# Sample Acquisition Trigger and FIFO Controller

This block is the digital core of a multi-source sampling front end. A host programs it through a small 16-bit register interface. It picks one conversion trigger, which can be a host write, an edge on an external pin, or the rising edge of one of three timer outputs. When the trigger fires, it sends a start pulse to an external converter and marks itself busy until the converter returns a result strobe.

Each result goes into a 4096-entry sample FIFO. The host empties the FIFO by reading the data offset. The status word reports:
- the busy flag,
- the empty, half-full and full flags,
- a sticky overrun flag.

A level interrupt follows one of six FIFO conditions, chosen by the host. Two self-clearing command bits act as resets: one clears the FIFO only, the other clears all acquisition state. Range, input-mode, channel-enable and gain settings are held and driven out as plain configuration outputs.

Top module: `smp_acq_ctrl`

## Requirements
- R1: After reset, a read of the control offset (0xA) returns 0x1000, which means only the empty flag is set. The channel-enable and gain registers read 0. No start pulse is issued. The interrupt is high within two cycles, because interrupt condition 0 (FIFO empty) is selected.
- R2: Control bits [2:0] select the trigger source: 0 none, 1 host write, 2 pin rising edge, 3 pin falling edge, 4/5/6 rising edge of timer output 0/1/2. In mode 1, a write of any value to the data offset (0x8) produces exactly one start pulse. In every other mode, such a write produces none.
- R3: The pin and timer inputs each pass through two synchronizing flops before edge detection. In mode 2 only a rising pin edge starts a conversion; in mode 3 only a falling pin edge does.
- R4: In modes 4 to 6, only a rising edge of the selected timer output starts a conversion. Its falling edge is ignored, and so are edges on the other timer outputs.
- R5: Status bit 15 (busy) is set from the start pulse until the result strobe. A trigger that arrives while busy is ignored.
- R6: With control bit 8 set, every result is written to the FIFO. A read of offset 0x8 returns the oldest stored sample and removes it. With bit 8 clear, results are discarded.
- R7: Status bit 12 is FIFO empty. Bit 14 is half full, meaning the level is at least 2049. Bit 13 is full, meaning the level is 4096.
- R8: A result that arrives while the FIFO is full and no read happens in the same cycle is dropped. It sets status bit 5 (overrun), which stays set until a FIFO reset or a global reset, including across later reads.
- R9: A read of offset 0x8 and a result strobe in the same cycle on a full FIFO both take effect. The oldest sample is returned, the new sample is stored, the level stays at 4096, and no overrun is flagged.
- R10: Control bits [11:9] select the interrupt condition: 0 empty, 1 not empty, 2 not half full, 3 half full, 4 not full, 5 full. Codes 6 and 7 never raise it. The interrupt is a level that follows the selected condition.
- R11: Writing 1 to control bit 12 empties the FIFO and clears overrun. The configuration bits written in the same word are kept, and bit 12 is not stored.
- R12: Writing 1 to control bit 13 empties the FIFO, clears overrun and busy, and leaves the channel-enable and gain registers unchanged. After it, a new trigger is accepted.
- R13: Control bit 3 drives `cfg_bipolar` and bit 4 drives `cfg_diff`. Offsets 0xC and 0xE hold the channel-enable and gain words, which are driven out and read back unchanged.
- R14: A read of offset 0x8 while the FIFO is empty returns 0 and leaves the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (removes a sample at offset 0x8) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| ext_trig_pin | input | 1 | External trigger input, asynchronous |
| timer_out | input | 3 | Timer outputs used as trigger sources, asynchronous |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_done | input | 1 | Converter result strobe |
| conv_result | input | 16 | Converter result, valid with `conv_done` |
| cfg_bipolar | output | 1 | Bipolar input range selected |
| cfg_diff | output | 1 | Differential input mode selected |
| chan_enable | output | 16 | Channel-enable word |
| gain_sel | output | 16 | Gain word |
| irq | output | 1 | Level interrupt |

## Verification
Two events can fall in the same cycle: a host read that removes the oldest sample, and the converter's result strobe pushing a new one while the FIFO holds 4096 entries. The bench fills the FIFO, triggers one more conversion, watches for the result strobe, and issues the data read in that same cycle. The outcome is judged in four ways:
- the returned sample must be the first one stored;
- the full flag must stay set;
- the overrun flag must stay clear;
- a full drain must produce every later sample in order, with the coinciding sample last and the next, dropped sample absent.

// File: rtl/smp_acq_pkg.sv
package smp_acq_pkg;

  // Register byte offsets
  localparam logic [3:0] OFS_DATA = 4'h8;
  localparam logic [3:0] OFS_CTRL = 4'hA;
  localparam logic [3:0] OFS_CHEN = 4'hC;
  localparam logic [3:0] OFS_GAIN = 4'hE;

  // Trigger source codes (control bits [2:0])
  localparam logic [2:0] TRG_OFF      = 3'd0;
  localparam logic [2:0] TRG_SOFT     = 3'd1;
  localparam logic [2:0] TRG_PIN_RISE = 3'd2;
  localparam logic [2:0] TRG_PIN_FALL = 3'd3;
  localparam logic [2:0] TRG_TMR_BASE = 3'd4;

  // Interrupt condition codes (control bits [11:9])
  localparam logic [2:0] IRQ_EMPTY  = 3'd0;
  localparam logic [2:0] IRQ_NEMPTY = 3'd1;
  localparam logic [2:0] IRQ_NHALF  = 3'd2;
  localparam logic [2:0] IRQ_HALF   = 3'd3;
  localparam logic [2:0] IRQ_NFULL  = 3'd4;
  localparam logic [2:0] IRQ_FULL   = 3'd5;

  typedef struct packed {
    logic [2:0] irq_sel;
    logic       fifo_en;
    logic       diff;
    logic       bipolar;
    logic [2:0] trig_sel;
  } acq_cfg_t;

  typedef struct packed {
    logic empty;
    logic half;
    logic full;
  } fifo_flags_t;

  // Interrupt condition selected by code over the current FIFO flags.
  function automatic logic irq_eval(logic [2:0] sel, fifo_flags_t f);
    logic r;
    case (sel)
      IRQ_EMPTY:  r = f.empty;
      IRQ_NEMPTY: r = !f.empty;
      IRQ_NHALF:  r = !f.half;
      IRQ_HALF:   r = f.half;
      IRQ_NFULL:  r = !f.full;
      IRQ_FULL:   r = f.full;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

  // Status word seen on a read of the control offset.
  function automatic logic [15:0] status_word(acq_cfg_t c, logic busy, logic ovr,
                                              fifo_flags_t f);
    return {busy, f.half, f.full, f.empty, c.irq_sel, c.fifo_en, 2'b00, ovr,
            c.diff, c.bipolar, c.trig_sel};
  endfunction

endpackage

// File: rtl/smp_trig_sel.sv
module smp_trig_sel
  import smp_acq_pkg::*;
#(
  parameter int N_TMR = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel,
  input  logic             sw_hit,
  input  logic             pin,
  input  logic [N_TMR-1:0] tmr,
  output logic             fire
);

  localparam int N_SRC = N_TMR + 1;

  logic [N_SRC-1:0] raw;
  logic [N_SRC-1:0] s_now;
  logic [N_SRC-1:0] s_old;
  logic [N_SRC-1:0] rise;
  logic             pin_fall;

  assign raw = {tmr, pin};

  // Two synchronizing flops plus one history flop per source
  for (genvar g = 0; g < N_SRC; g++) begin : g_sync
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], raw[g]};
    end
    assign s_now[g] = sh[1];
    assign s_old[g] = sh[2];
  end

  assign rise     = s_now & ~s_old;
  assign pin_fall = !s_now[0] && s_old[0];

  always_comb begin
    fire = 1'b0;
    case (sel)
      TRG_OFF:      fire = 1'b0;
      TRG_SOFT:     fire = sw_hit;
      TRG_PIN_RISE: fire = rise[0];
      TRG_PIN_FALL: fire = pin_fall;
      default: begin
        for (int t = 0; t < N_TMR; t++) begin
          if (int'(sel) == int'(TRG_TMR_BASE) + t) fire = rise[t+1];
        end
      end
    endcase
  end

endmodule

// File: rtl/smp_conv_seq.sv
module smp_conv_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic fire,
  input  logic done,
  output logic start,
  output logic busy
);

  logic accept;

  assign accept = fire && !busy && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start <= 1'b0;
      busy  <= 1'b0;
    end else begin
      start <= accept;
      if (abort)       busy <= 1'b0;
      else if (accept) busy <= 1'b1;
      else if (done)   busy <= 1'b0;
    end
  end

endmodule

// File: rtl/smp_sfifo.sv
module smp_sfifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4096
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty,
  output logic                       full,
  output logic                       half,
  output logic                       drop
);

  localparam int AW        = $clog2(DEPTH);
  localparam int CW        = AW + 1;
  localparam int HALF_MARK = DEPTH / 2 + 1;

  function automatic logic at_least(logic [CW-1:0] c, int mark);
    return int'(c) >= mark;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic [CW-1:0] cnt;
  logic          do_push;
  logic          do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign half    = at_least(cnt, HALF_MARK);
  assign do_pop  = pop && !clr && !empty;
  assign do_push = push && !clr && (!full || do_pop);
  assign drop    = push && !clr && !do_push;
  assign level   = cnt;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/smp_irq_gen.sv
module smp_irq_gen
  import smp_acq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  sel,
  input  fifo_flags_t flags,
  output logic        irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_eval(sel, flags);
  end

endmodule

// File: rtl/smp_acq_ctrl.sv
module smp_acq_ctrl
  import smp_acq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 4096,
  parameter int N_TMR = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic             ext_trig_pin,
  input  logic [N_TMR-1:0] timer_out,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [DW-1:0]    conv_result,
  output logic             cfg_bipolar,
  output logic             cfg_diff,
  output logic [15:0]      chan_enable,
  output logic [15:0]      gain_sel,
  output logic             irq
);

  localparam int CW = $clog2(DEPTH) + 1;

  // Register decode
  logic wr_data, wr_ctrl, wr_chen, wr_gain, rd_data;
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_chen = bus_wr && (bus_addr == OFS_CHEN);
  assign wr_gain = bus_wr && (bus_addr == OFS_GAIN);
  assign rd_data = bus_rd && (bus_addr == OFS_DATA);

  // Self-clearing command pulses (not stored)
  logic glob_clr, fifo_clr;
  assign glob_clr = wr_ctrl && bus_wdata[13];
  assign fifo_clr = wr_ctrl && (bus_wdata[12] || bus_wdata[13]);

  acq_cfg_t    cfg_q;
  logic [15:0] chen_q;
  logic [15:0] gain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      chen_q <= '0;
      gain_q <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg_q.irq_sel  <= bus_wdata[11:9];
        cfg_q.fifo_en  <= bus_wdata[8];
        cfg_q.diff     <= bus_wdata[4];
        cfg_q.bipolar  <= bus_wdata[3];
        cfg_q.trig_sel <= bus_wdata[2:0];
      end
      if (wr_chen) chen_q <= bus_wdata;
      if (wr_gain) gain_q <= bus_wdata;
    end
  end

  // Trigger selection and conversion sequencing
  logic trig_fire;
  logic conv_busy;

  smp_trig_sel #(.N_TMR(N_TMR)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (cfg_q.trig_sel),
    .sw_hit (wr_data),
    .pin    (ext_trig_pin),
    .tmr    (timer_out),
    .fire   (trig_fire)
  );

  smp_conv_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .abort (glob_clr),
    .fire  (trig_fire),
    .done  (conv_done),
    .start (conv_start),
    .busy  (conv_busy)
  );

  // Sample FIFO
  logic          fifo_push, fifo_pop, fifo_drop;
  logic          fifo_empty, fifo_full, fifo_half;
  logic [DW-1:0] fifo_dout;
  logic [CW-1:0] fifo_level;
  fifo_flags_t   fifo_flags;

  assign fifo_push = conv_done && cfg_q.fifo_en;
  assign fifo_pop  = rd_data;

  smp_sfifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .din   (conv_result),
    .dout  (fifo_dout),
    .level (fifo_level),
    .empty (fifo_empty),
    .full  (fifo_full),
    .half  (fifo_half),
    .drop  (fifo_drop)
  );

  assign fifo_flags = '{empty: fifo_empty, half: fifo_half, full: fifo_full};

  // Sticky overrun
  logic ovr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovr_q <= 1'b0;
    else if (fifo_clr)  ovr_q <= 1'b0;
    else if (fifo_drop) ovr_q <= 1'b1;
  end

  smp_irq_gen u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (cfg_q.irq_sel),
    .flags (fifo_flags),
    .irq   (irq)
  );

  // Read mux
  always_comb begin
    case (bus_addr)
      OFS_DATA: bus_rdata = fifo_empty ? 16'h0000 : 16'(fifo_dout);
      OFS_CTRL: bus_rdata = status_word(cfg_q, conv_busy, ovr_q, fifo_flags);
      OFS_CHEN: bus_rdata = chen_q;
      OFS_GAIN: bus_rdata = gain_q;
      default:  bus_rdata = 16'h0000;
    endcase
  end

  assign cfg_bipolar = cfg_q.bipolar;
  assign cfg_diff    = cfg_q.diff;
  assign chan_enable = chen_q;
  assign gain_sel    = gain_q;

endmodule

// File: rtl/smp_acq_chk.sv
module smp_acq_chk #(
  parameter int DEPTH = 4096,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_start,
  input logic          conv_done,
  input logic          busy,
  input logic          fire,
  input logic          glob_clr,
  input logic          fifo_clr,
  input logic          push,
  input logic          pop,
  input logic          drop,
  input logic          empty,
  input logic          full,
  input logic [CW-1:0] level,
  input logic          ovr
);

  // R2: a start is a single-cycle pulse
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R5: a start always coincides with busy
  a_r5_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  // R5: a trigger seen while busy produces no start
  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fire && busy |=> !conv_start);

  // R5/R12: busy only drops on a result strobe or a global reset
  a_r5_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_done || glob_clr));

  // R7: flags never contradict each other and the level stays in range
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R8: overrun rises only after a dropped result, and holds until a clear
  a_r8_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(drop));

  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !fifo_clr |=> ovr);

  // R11: a FIFO clear empties it and drops overrun
  a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> empty && !ovr);

  // R14: reading an empty FIFO with no incoming sample leaves it empty
  a_r14_empty_read_noop: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push |=> empty);

endmodule

bind smp_acq_ctrl smp_acq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .busy       (conv_busy),
  .fire       (trig_fire),
  .glob_clr   (glob_clr),
  .fifo_clr   (fifo_clr),
  .push       (fifo_push),
  .pop        (fifo_pop),
  .drop       (fifo_drop),
  .empty      (fifo_empty),
  .full       (fifo_full),
  .level      (fifo_level),
  .ovr        (ovr_q)
);

// File: tb/tb_smp_acq_ctrl.sv
module tb_smp_acq_ctrl;

  localparam int LAT  = 6;
  localparam int FULL = 4096;
  localparam logic [3:0] A_DATA = 4'h8;
  localparam logic [3:0] A_CTRL = 4'hA;
  localparam logic [3:0] A_CHEN = 4'hC;
  localparam logic [3:0] A_GAIN = 4'hE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        ext_trig_pin;
  logic [2:0]  timer_out;
  logic        conv_start, conv_done;
  logic [15:0] conv_result;
  logic        cfg_bipolar, cfg_diff;
  logic [15:0] chan_enable, gain_sel;
  logic        irq;

  int          n_checks = 0;
  int          n_errs   = 0;
  int          n_starts = 0;
  int          cd_cnt   = 0;
  logic [15:0] next_val = 16'h1000;
  bit          finished = 0;

  always #4 clk = ~clk;

  smp_acq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_trig_pin(ext_trig_pin), .timer_out(timer_out),
    .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
    .cfg_bipolar(cfg_bipolar), .cfg_diff(cfg_diff),
    .chan_enable(chan_enable), .gain_sel(gain_sel), .irq(irq)
  );

  // Converter model: result strobe LAT cycles after a start pulse
  initial begin
    conv_done = 1'b0;
    conv_result = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (cd_cnt > 0) begin
        cd_cnt--;
        if (cd_cnt == 0) begin
          conv_done   = 1'b1;
          conv_result = next_val;
          next_val    = next_val + 16'd1;
        end
      end
      if (conv_start) begin
        cd_cnt = LAT;
        n_starts++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic convert_n(input int n);
    repeat (n) begin
      bus_write(A_DATA, 16'h5A5A);
      idle(LAT + 3);
    end
  endtask

  task automatic t_reset_state;
    logic [15:0] v;
    idle(2);
    bus_read(A_CTRL, v); chk("R1 status after reset", v, 16'h1000);
    bus_read(A_CHEN, v); chk("R1 chan enable after reset", v, 16'h0000);
    bus_read(A_GAIN, v); chk("R1 gain after reset", v, 16'h0000);
    chk("R1 irq on empty", irq, 1'b1);
    chk("R1 no start", n_starts, 0);
  endtask

  task automatic t_config;
    logic [15:0] v;
    bus_write(A_CTRL, 16'h0018);
    idle(1);
    chk("R13 bipolar out", cfg_bipolar, 1'b1);
    chk("R13 diff out", cfg_diff, 1'b1);
    bus_read(A_CTRL, v); chk("R13 ctrl readback", v, 16'h1018);
    bus_write(A_CHEN, 16'h00F3);
    bus_write(A_GAIN, 16'hA5C3);
    chk("R13 chan enable out", chan_enable, 16'h00F3);
    chk("R13 gain out", gain_sel, 16'hA5C3);
    bus_read(A_GAIN, v); chk("R13 gain readback", v, 16'hA5C3);
    bus_write(A_CTRL, 16'h0000);
    idle(1);
    chk("R13 bipolar cleared", cfg_bipolar, 1'b0);
  endtask

  task automatic t_sw_trigger;
    int s0;
    bus_write(A_CTRL, 16'h0100);
    s0 = n_starts;
    bus_write(A_DATA, 16'h1234); idle(12);
    chk("R2 no trigger in mode 0", n_starts, s0);
    bus_write(A_CTRL, 16'h0101);
    bus_write(A_DATA, 16'h0000); idle(12);
    chk("R2 host write starts once", n_starts, s0 + 1);
    bus_write(A_CTRL, 16'h0102);
    bus_write(A_DATA, 16'hFFFF); idle(12);
    chk("R2 host write ignored in pin mode", n_starts, s0 + 1);
    bus_write(A_CTRL, 16'h1100);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] v;
    int s0;
    bus_write(A_CTRL, 16'h0101);
    s0 = n_starts;
    bus_write(A_DATA, 16'h0001);
    bus_write(A_DATA, 16'h0002);
    bus_read(A_CTRL, v); chk("R5 busy bit set", v[15], 1'b1);
    idle(14);
    chk("R5 trigger while busy ignored", n_starts, s0 + 1);
    bus_read(A_CTRL, v); chk("R5 busy bit clear after result", v[15], 1'b0);
    bus_read(A_DATA, v);
    bus_read(A_CTRL, v); chk("R5 exactly one sample stored", v[12], 1'b1);
  endtask

  task automatic t_pin_edges;
    int s0;
    bus_write(A_CTRL, 16'h0102);
    s0 = n_starts;
    ext_trig_pin = 1'b1; idle(14);
    chk("R3 rising pin in mode 2", n_starts, s0 + 1);
    ext_trig_pin = 1'b0; idle(14);
    chk("R3 falling pin ignored in mode 2", n_starts, s0 + 1);
    bus_write(A_CTRL, 16'h0103);
    ext_trig_pin = 1'b1; idle(14);
    chk("R3 rising pin ignored in mode 3", n_starts, s0 + 1);
    ext_trig_pin = 1'b0; idle(14);
    chk("R3 falling pin in mode 3", n_starts, s0 + 2);
    bus_write(A_CTRL, 16'h1100);
  endtask

  task automatic t_timer_edges;
    int s0;
    for (int t = 0; t < 3; t++) begin
      bus_write(A_CTRL, 16'h0104 + 16'(t));
      s0 = n_starts;
      for (int o = 0; o < 3; o++) begin
        if (o != t) begin
          timer_out[o] = 1'b1; idle(6);
          timer_out[o] = 1'b0; idle(6);
        end
      end
      chk("R4 other timers ignored", n_starts, s0);
      timer_out[t] = 1'b1; idle(14);
      chk("R4 selected timer rising", n_starts, s0 + 1);
      timer_out[t] = 1'b0; idle(14);
      chk("R4 selected timer falling ignored", n_starts, s0 + 1);
    end
    bus_write(A_CTRL, 16'h1100);
  endtask

  task automatic t_fifo_order;
    logic [15:0] v, base;
    bus_write(A_CTRL, 16'h1101);
    base = next_val;
    convert_n(3);
    bus_read(A_DATA, v); chk("R6 first sample", v, base);
    bus_read(A_DATA, v); chk("R6 second sample", v, base + 16'd1);
    bus_read(A_DATA, v); chk("R6 third sample", v, base + 16'd2);
    bus_write(A_CTRL, 16'h0001);
    convert_n(1);
    bus_read(A_CTRL, v); chk("R6 disabled FIFO keeps nothing", v, 16'h1001);
  endtask

  task automatic t_empty_read;
    logic [15:0] v, base;
    bus_write(A_CTRL, 16'h1101);
    bus_read(A_DATA, v); chk("R14 empty read returns 0", v, 16'h0000);
    bus_read(A_CTRL, v); chk("R14 still empty", v, 16'h1101);
    base = next_val;
    convert_n(1);
    bus_read(A_DATA, v); chk("R14 FIFO works after empty read", v, base);
  endtask

  task automatic t_irq_small;
    for (int lvl = 0; lvl < 2; lvl++) begin
      for (int s = 0; s < 8; s++) begin
        logic e;
        bus_write(A_CTRL, 16'h0101 | 16'(s << 9));
        idle(2);
        if (lvl == 0) e = (s == 0) || (s == 2) || (s == 4);
        else          e = (s == 1) || (s == 2) || (s == 4);
        chk($sformatf("R10 irq level=%0d cond=%0d", lvl, s), irq, e);
      end
      if (lvl == 0) begin
        bus_write(A_CTRL, 16'h0101);
        convert_n(1);
      end
    end
    bus_write(A_CTRL, 16'h1101);
  endtask

  task automatic t_fill_overrun;
    logic [15:0] v, base;
    int bad;
    bus_write(A_CTRL, 16'h1101);
    base = next_val;
    convert_n(2048);
    bus_read(A_CTRL, v); chk("R7 level 2048 not half", v, 16'h0101);
    bus_write(A_CTRL, 16'h0501); idle(2);
    chk("R10 not-half irq", irq, 1'b1);
    bus_write(A_CTRL, 16'h0701); idle(2);
    chk("R10 half irq low at 2048", irq, 1'b0);
    convert_n(1);
    bus_read(A_CTRL, v); chk("R7 half at 2049", v, 16'h4701);
    chk("R10 half irq at 2049", irq, 1'b1);
    convert_n(FULL - 2049);
    bus_read(A_CTRL, v); chk("R7 full at 4096", v, 16'h6701);
    bus_write(A_CTRL, 16'h0B01); idle(2);
    chk("R10 full irq", irq, 1'b1);
    bus_write(A_CTRL, 16'h0901); idle(2);
    chk("R10 not-full irq low", irq, 1'b0);
    // R9: read and result strobe in the same cycle on a full FIFO
    bus_write(A_DATA, 16'h0000);
    forever begin
      @(negedge clk); #1;
      if (conv_done) break;
    end
    bus_addr = A_DATA; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    chk("R9 coincident read returns oldest", v, base);
    bus_read(A_CTRL, v); chk("R9 still full, no overrun", v, 16'h6901);
    // R8: one more result overflows
    convert_n(1);
    bus_read(A_CTRL, v); chk("R8 overrun set while full", v, 16'h6921);
    bus_read(A_DATA, v); chk("R8 oldest kept after drop", v, base + 16'd1);
    bus_read(A_CTRL, v); chk("R8 overrun sticky after read", v, 16'h4921);
    bad = 0;
    for (int i = 2; i <= FULL; i++) begin
      bus_read(A_DATA, v);
      if (v !== base + 16'(i)) bad++;
    end
    chk("R9 drained order incl. coincident sample", bad, 0);
    bus_read(A_CTRL, v); chk("R8 overrun held when empty", v, 16'h1921);
    bus_write(A_CTRL, 16'h1101);
    bus_read(A_CTRL, v); chk("R11 FIFO reset clears overrun", v, 16'h1101);
  endtask

  task automatic t_fifo_reset;
    logic [15:0] v;
    bus_write(A_CTRL, 16'h0101);
    convert_n(2);
    bus_write(A_CTRL, 16'h1309);
    bus_read(A_CTRL, v); chk("R11 reset keeps config, empties", v, 16'h1309);
    chk("R11 bipolar kept", cfg_bipolar, 1'b1);
    bus_read(A_DATA, v); chk("R11 no stale samples", v, 16'h0000);
  endtask

  task automatic t_global_reset;
    logic [15:0] v;
    int s0;
    bus_write(A_CTRL, 16'h0101);
    convert_n(1);
    s0 = n_starts;
    bus_write(A_DATA, 16'h0000);
    bus_write(A_CTRL, 16'h2101);
    bus_read(A_CTRL, v); chk("R12 busy and FIFO cleared", v, 16'h1101);
    bus_read(A_CHEN, v); chk("R12 chan enable kept", v, 16'h00F3);
    bus_read(A_GAIN, v); chk("R12 gain kept", v, 16'hA5C3);
    idle(14);
    bus_write(A_CTRL, 16'h1101);
    bus_write(A_DATA, 16'h0000); idle(12);
    chk("R12 new trigger accepted", n_starts, s0 + 2);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    ext_trig_pin = 1'b0; timer_out = '0;
    idle(4);
    rst_n = 1'b1;
    t_reset_state;
    t_config;
    t_sw_trigger;
    t_busy_ignore;
    t_pin_edges;
    t_timer_edges;
    t_fifo_order;
    t_empty_read;
    t_irq_small;
    t_fill_overrun;
    t_fifo_reset;
    t_global_reset;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

endmodule